// File: doc/BRIEF.md
# Indirect Extended-Register Access Bridge

This block sits on the management-register side of a PHY. A host that can only address a 32-entry register file (5-bit register number, 16-bit data) reaches a larger extended register array through two small registers: an access control register (register 13) and a shared address/data register (register 14). The control register latches a target device address and an access function. The address/data register either loads a 16-bit extended address pointer or moves data to and from the extended array at that pointer.

Three data functions exist. One leaves the pointer unchanged. One advances it after every data read and every data write. One advances it after data writes only. Register-block sweeps therefore need no fresh address write per word. A typical read writes the device address to register 13, writes the target address to register 14, rewrites register 13 with the device address and a data function, and then reads register 14.

A second, local port gives the rest of the PHY direct read and write access to the same array. The array has no reset and is built so that it maps to block RAM.

Top module: `mmd_bridge`

## Requirements
- R1: After reset the control register reads 0x0000, the address pointer is 0x0000 (register 14 reads 0x0000), and `reg_rvalid` is low.
- R2: A write to register 13 latches bits [15:14] as the function and bits [4:0] as the device address. A read of register 13 returns the function in [15:14], the device address in [4:0], and zero in [13:5].
- R3: With function 00, a write to register 14 loads the address pointer, and a read of register 14 returns the pointer.
- R4: With function 01, a register 14 read returns the array word at the pointer and a register 14 write stores to it. The pointer is unchanged by either.
- R5: With function 10, the pointer increments by one after every register 14 data read and every register 14 data write.
- R6: With function 11, the pointer increments by one after every register 14 data write, and a register 14 data read leaves it unchanged.
- R7: Pointer increment wraps from 0xFFFF to 0x0000.
- R8: If the latched device address differs from parameter DEV_ID (default 0x1F), register 14 data reads return 0x0000, data writes leave the array unchanged, and the pointer does not move.
- R9: A data access at a pointer value of DEPTH or above reads 0x0000 and writes nothing, even where the low address bits alias an existing word. The pointer still follows its function.
- R10: Read data appears on `reg_rdata` with `reg_rvalid` high exactly one cycle after a `reg_rd` without `reg_wr`, and `reg_rvalid` is low otherwise. Registers other than 13 and 14 read 0x0000, and writes to them change nothing.
- R11: `loc_we` writes `loc_wdata` to `loc_addr`, and `loc_rdata` shows the word at `loc_addr` one cycle later. If a local write and a host data write occur in the same cycle, only the local write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (ignored when reg_wr is high) |
| reg_num | input | 5 | Host register number |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| loc_we | input | 1 | Local array write enable |
| loc_addr | input | AW | Local array word address |
| loc_wdata | input | 16 | Local array write data |
| loc_rdata | output | 16 | Local array read data, one cycle after loc_addr |

## Verification
The bench sweeps the whole array in every data function. After each sweep it reads the pointer back in address mode. A design that stepped on the wrong access type, or not at all, would leave the pointer on the wrong value. It drives the pointer to 0xFFFF and to values past the array end. An increment without a wrap, or a range check done only on the low address bits, would show up as a nonzero pointer or as a corrupted aliased word on the local port. It also issues accesses under a foreign device address and makes a host write collide with a local write to the same word. Leaking data, moving the pointer or letting the wrong writer win would each show as a wrong value on readback.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam logic [4:0] REG_CTRL = 5'd13;
  localparam logic [4:0] REG_DATA = 5'd14;

  typedef enum logic [1:0] {
    FN_ADDR   = 2'b00,
    FN_DATA   = 2'b01,
    FN_INC_RW = 2'b10,
    FN_INC_W  = 2'b11
  } mmd_fn_e;

  typedef enum logic [1:0] {
    RB_ZERO = 2'd0,
    RB_SNAP = 2'd1,
    RB_RAM  = 2'd2
  } rb_sel_e;
endpackage

// File: rtl/mmd_access_ctrl.sv
module mmd_access_ctrl
  import mmd_pkg::*;
#(
  parameter int         DW     = 16,
  parameter int         DEPTH  = 512,
  parameter logic [4:0] DEV_ID = 5'h1F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [4:0]    num,
  input  logic [DW-1:0] wdata,
  output mmd_fn_e       fn,
  output logic [4:0]    devad,
  output logic [DW-1:0] ptr,
  output logic          data_hit,
  output logic          in_range,
  output logic          ram_we
);
  localparam logic [31:0] DEPTH_U = 32'(DEPTH);

  logic is_ctrl, is_data, rd_only, step;

  assign is_ctrl  = (num == REG_CTRL);
  assign is_data  = (num == REG_DATA);
  assign rd_only  = rd && !wr;
  assign data_hit = is_data && (fn != FN_ADDR) && (devad == DEV_ID);
  assign in_range = ({{(32-DW){1'b0}}, ptr} < DEPTH_U);
  assign ram_we   = wr && data_hit && in_range;

  always_comb begin
    step = 1'b0;
    if (data_hit) begin
      if (wr && (fn == FN_INC_RW || fn == FN_INC_W)) step = 1'b1;
      else if (rd_only && fn == FN_INC_RW)           step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fn    <= FN_ADDR;
      devad <= 5'd0;
      ptr   <= '0;
    end else begin
      if (wr && is_ctrl) begin
        fn    <= mmd_fn_e'(wdata[15:14]);
        devad <= wdata[4:0];
      end
      if (wr && is_data && fn == FN_ADDR) ptr <= wdata;
      else if (step)                      ptr <= ptr + 1'b1;
    end
  end

  assert_incr_rd_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_only && is_data && fn == FN_INC_RW && devad == DEV_ID)
      |=> ptr == DW'($past(ptr) + 1'b1));

  assert_hold_data_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr || rd) && is_data && fn == FN_DATA) |=> $stable(ptr));

  assert_hold_rd_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_only && is_data && fn == FN_INC_W) |=> $stable(ptr));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && is_data && fn == FN_INC_W && devad == DEV_ID && ptr == {DW{1'b1}})
      |=> ptr == '0);

  assert_foreign_R8: assert property (@(posedge clk) disable iff (rst)
    ((wr || rd) && is_data && fn != FN_ADDR && devad != DEV_ID) |=> $stable(ptr));
endmodule

// File: rtl/mmd_ext_ram.sv
module mmd_ext_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we)      mem[b_addr] <= b_wdata;
    else if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

  assert_local_wins_R11: assert property (@(posedge clk)
    (b_we && a_we && a_addr == b_addr) |=> mem[$past(b_addr)] == $past(b_wdata));
endmodule

// File: rtl/mmd_bridge.sv
module mmd_bridge
  import mmd_pkg::*;
#(
  parameter int         DEPTH  = 512,
  parameter logic [4:0] DEV_ID = 5'h1F,
  localparam int        DW     = 16,
  localparam int        AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_num,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  mmd_fn_e       fn;
  logic [4:0]    devad;
  logic [DW-1:0] ptr;
  logic          data_hit, in_range, ram_we;
  logic [DW-1:0] ram_rd;
  logic          rd_go;
  rb_sel_e       sel_q;
  logic [DW-1:0] snap_q;

  assign rd_go = reg_rd && !reg_wr;

  mmd_access_ctrl #(.DW(DW), .DEPTH(DEPTH), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .num(reg_num),
    .wdata(reg_wdata), .fn(fn), .devad(devad), .ptr(ptr),
    .data_hit(data_hit), .in_range(in_range), .ram_we(ram_we)
  );

  mmd_ext_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .a_we(ram_we), .a_addr(ptr[AW-1:0]), .a_wdata(reg_wdata), .a_rdata(ram_rd),
    .b_we(loc_we), .b_addr(loc_addr), .b_wdata(loc_wdata), .b_rdata(loc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      sel_q      <= RB_ZERO;
      snap_q     <= '0;
    end else begin
      reg_rvalid <= rd_go;
      if (rd_go) begin
        sel_q  <= RB_ZERO;
        snap_q <= '0;
        if (reg_num == REG_CTRL) begin
          sel_q  <= RB_SNAP;
          snap_q <= {fn, 9'd0, devad};
        end else if (reg_num == REG_DATA) begin
          if (fn == FN_ADDR) begin
            sel_q  <= RB_SNAP;
            snap_q <= ptr;
          end else if (data_hit && in_range) begin
            sel_q  <= RB_RAM;
          end
        end
      end
    end
  end

  always_comb begin
    case (sel_q)
      RB_SNAP: reg_rdata = snap_q;
      RB_RAM:  reg_rdata = ram_rd;
      default: reg_rdata = '0;
    endcase
  end

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> reg_rvalid);

  assert_rvalid_low_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> !reg_rvalid);

  assert_foreign_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_go && reg_num == REG_DATA && fn != FN_ADDR && devad != DEV_ID)
      |=> reg_rdata == '0);

  assert_other_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_go && reg_num != REG_DATA && reg_num != REG_CTRL) |=> reg_rdata == '0);
endmodule

// File: tb/sim_mmd_bridge.sv
`timescale 1ns/1ps
module sim_mmd_bridge;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_num = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;
  logic          loc_we = 1'b0;
  logic [AW-1:0] loc_addr = '0;
  logic [15:0]   loc_wdata = '0;
  logic [15:0]   loc_rdata;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [DEPTH];
  logic [15:0] v;

  always #2.5 clk = ~clk;

  mmd_bridge #(.DEPTH(DEPTH), .DEV_ID(5'h1F)) u0 (
    .clk, .rst, .reg_wr, .reg_rd, .reg_num, .reg_wdata, .reg_rdata,
    .reg_rvalid, .loc_we, .loc_addr, .loc_wdata, .loc_rdata
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h3B1D) ^ 16'hA5C3);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_num = n; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_num = n;
    @(negedge clk); reg_rd = 1'b0;
    d = reg_rdata;
    chk("R10 rvalid high", {15'd0, reg_rvalid}, 16'd1);
    @(negedge clk);
    chk("R10 rvalid low", {15'd0, reg_rvalid}, 16'd0);
  endtask

  task automatic lwr(input int a, input logic [15:0] d);
    @(negedge clk); loc_we = 1'b1; loc_addr = AW'(a); loc_wdata = d;
    @(negedge clk); loc_we = 1'b0;
  endtask

  task automatic lrd(input int a, output logic [15:0] d);
    @(negedge clk); loc_addr = AW'(a);
    @(negedge clk); d = loc_rdata;
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rvalid", {15'd0, reg_rvalid}, 16'd0);
    rd(5'd13, v); chk("R1 ctrl", v, 16'h0000);
    rd(5'd14, v); chk("R1 pointer", v, 16'h0000);

    // R2 field latching
    wr(5'd13, 16'hC01F); rd(5'd13, v); chk("R2 ctrl", v, 16'hC01F);
    wr(5'd13, 16'h3FFF); rd(5'd13, v); chk("R2 ctrl masked", v, 16'h001F);

    // R3 address load
    wr(5'd14, 16'h0007); rd(5'd14, v); chk("R3 pointer", v, 16'h0007);

    for (int a = 0; a < DEPTH; a++) begin lwr(a, pat(a)); model[a] = pat(a); end

    // R5 read sweep
    wr(5'd14, 16'h0000); wr(5'd13, 16'h801F);
    for (int a = 0; a < DEPTH; a++) begin rd(5'd14, v); chk("R5 read sweep", v, model[a]); end
    wr(5'd13, 16'h001F); rd(5'd14, v); chk("R5 pointer after reads", v, 16'(DEPTH));

    // R6 write sweep
    wr(5'd14, 16'h0000); wr(5'd13, 16'hC01F);
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = ~pat(a) ^ 16'(a);
      wr(5'd14, model[a]);
    end
    rd(5'd14, v); chk("R9 out of range read", v, 16'h0000);
    wr(5'd13, 16'h001F); rd(5'd14, v); chk("R6 pointer after writes", v, 16'(DEPTH));
    for (int a = 0; a < DEPTH; a++) begin lrd(a, v); chk("R11 local read", v, model[a]); end

    // R4 no increment
    wr(5'd14, 16'h0005); wr(5'd13, 16'h401F);
    rd(5'd14, v); chk("R4 read", v, model[5]);
    rd(5'd14, v); chk("R4 reread", v, model[5]);
    wr(5'd14, 16'h1234); model[5] = 16'h1234;
    rd(5'd14, v); chk("R4 write", v, 16'h1234);
    wr(5'd13, 16'h001F); rd(5'd14, v); chk("R4 pointer", v, 16'h0005);

    // R9 beyond the array, aliasing word 8
    wr(5'd14, 16'd40); wr(5'd13, 16'h801F);
    rd(5'd14, v); chk("R9 read zero", v, 16'h0000);
    wr(5'd14, 16'hBEEF);
    wr(5'd13, 16'h001F); rd(5'd14, v); chk("R9 pointer moves", v, 16'd42);
    lrd(8, v); chk("R9 alias untouched", v, model[8]);

    // R7 wrap on write and on read
    wr(5'd14, 16'hFFFF); wr(5'd13, 16'hC01F); wr(5'd14, 16'h7777);
    wr(5'd13, 16'h001F); rd(5'd14, v); chk("R7 wrap write", v, 16'h0000);
    lrd(31, v); chk("R7 alias untouched", v, model[31]);
    wr(5'd14, 16'hFFFF); wr(5'd13, 16'h801F); rd(5'd14, v);
    wr(5'd13, 16'h001F); rd(5'd14, v); chk("R7 wrap read", v, 16'h0000);

    // R8 foreign device address
    wr(5'd14, 16'h0003); wr(5'd13, 16'h4001);
    rd(5'd14, v); chk("R8 read zero", v, 16'h0000);
    wr(5'd14, 16'hDEAD);
    rd(5'd13, v); chk("R8 ctrl", v, 16'h4001);
    wr(5'd13, 16'h8001); rd(5'd14, v); wr(5'd14, 16'hDEAD);
    wr(5'd13, 16'h0001); rd(5'd14, v); chk("R8 pointer still", v, 16'h0003);
    wr(5'd13, 16'h401F); rd(5'd14, v); chk("R8 word intact", v, model[3]);

    // R10 other registers
    wr(5'd5, 16'hFFFF);
    rd(5'd5, v);  chk("R10 reg5 zero", v, 16'h0000);
    rd(5'd13, v); chk("R10 ctrl unchanged", v, 16'h401F);
    rd(5'd0, v);  chk("R10 reg0 zero", v, 16'h0000);
    rd(5'd31, v); chk("R10 reg31 zero", v, 16'h0000);

    // R11 collision, pointer is 3, function 01
    @(negedge clk);
    reg_wr = 1'b1; reg_num = 5'd14; reg_wdata = 16'h1111;
    loc_we = 1'b1; loc_addr = AW'(3); loc_wdata = 16'h2222;
    @(negedge clk); reg_wr = 1'b0; loc_we = 1'b0; model[3] = 16'h2222;
    lrd(3, v); chk("R11 local wins", v, 16'h2222);
    rd(5'd14, v); chk("R11 host view", v, 16'h2222);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule